// File: doc/BRIEF.md
# Configurable Trigger Match Unit

This block watches a group of probe signals on every clock and decides whether the current sample satisfies a programmed trigger condition. Three base compares are offered: masked equality with a per-bit don't-care, a magnitude compare (equal, not equal, greater, less) of the masked probe against a pattern, and an inclusive window compare against a low and a high bound. Each base compare can also be qualified by per-bit transitions (rising, falling or either edge), which gives six modes in all.

A match is reported as a registered pulse one cycle after the sample that caused it. An occurrence counter follows the compare, so a trigger can wait for the N-th matching cycle before its sticky count-reached flag rises. The flag stays set until an arm/clear pulse restarts the count. Setting the counter width parameter to zero removes the counter, and the flag then rises on the first match.

Top module: `trig_match_unit`

## Requirements
- R1: While rst_n is low at a clock edge, match_o and count_hit_o are low after that edge, and the occurrence count restarts from zero.
- R2: Mode 0 (basic) matches when every probe bit with care_i set equals the same bit of pat_lo_i; bits with care_i clear are ignored.
- R3: match_o is registered: it reflects the compare of the inputs sampled at the previous rising clock edge and is not affected by inputs applied since that edge.
- R4: Mode 2 (extended) compares the unsigned value probe_i & care_i with pat_lo_i & care_i using ext_op_i: 0 equal, 1 not equal, 2 greater than, 3 less than.
- R5: Mode 4 (range) matches when pat_lo_i <= (probe_i & care_i) <= pat_hi_i, bounds inclusive; with range_out_i set it matches exactly when that window test fails.
- R6: Modes 1, 3 and 5 add edge qualification to modes 0, 2 and 4. Bit i takes the code edge_sel_i[2i+1:2i]: 0 level, 1 rising (0 then 1), 2 falling (1 then 0), 3 either change, judged between the previous and current sample. Every cared bit with a nonzero code must show its transition. In mode 1 such bits are left out of the equality test; in modes 3 and 5 the magnitude or window test still uses the whole masked probe.
- R7: A bit coded for an edge cannot be satisfied before one probe sample has been taken since reset.
- R8: Mode codes 6 and 7 never produce a match.
- R9: The counter advances once per cycle in which the compare holds. count_hit_o rises at the same edge as the match_o pulse of the target_i-th such cycle since the last clear; a target of 0 behaves as 1.
- R10: count_hit_o stays high until arm_clr_i is sampled high. That edge clears the flag and the count, and a match in that same cycle is not counted. Matches while the flag is set do not change the count.
- R11: With the counter width parameter CNT_W set to 0, count_hit_o rises at the first match after reset or clear, and target_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| probe_i | input | WIDTH | Monitored signal group |
| mode_i | input | 3 | Compare mode, 0 to 5 legal |
| pat_lo_i | input | WIDTH | Pattern value, or low bound in range modes |
| pat_hi_i | input | WIDTH | High bound in range modes |
| care_i | input | WIDTH | Per-bit compare enable, 0 = don't care |
| edge_sel_i | input | 2*WIDTH | Per-bit transition code for edge modes |
| ext_op_i | input | 2 | Operator for extended modes |
| range_out_i | input | 1 | Match outside the window instead of inside |
| target_i | input | max(CNT_W,1) | Number of matches to await |
| arm_clr_i | input | 1 | Clears count and count-reached flag |
| match_o | output | 1 | Registered match pulse |
| count_hit_o | output | 1 | Sticky count-reached flag |

## Verification
The bench aims at the magnitude and window boundaries: a probe equal to a bound must match in range mode and fail strict greater or less, so an off-by-one comparator shows up as a match in the wrong cycle. It drives an edge-coded bit high in the very first cycle after reset, where a design that trusts the reset value of its history register would report a false rising edge. It counts to targets of 0, 1 and several, clears in a cycle that also matches, and keeps matching after the flag is set; a counter that counts the clearing cycle, treats target 0 as never, or lets the flag drop would miss the expected edge. A second instance without a counter catches a zero-width build that never fires.

// File: rtl/trig_match_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings for the trigger match unit.
// Assumes: mode codes above 5 are illegal and must never match.
package trig_match_pkg;

    // Compare mode: bit 0 selects edge qualification, bits 2:1 the base compare.
    typedef enum logic [2:0] {
        MODE_BASIC      = 3'd0,
        MODE_BASIC_EDGE = 3'd1,
        MODE_EXT        = 3'd2,
        MODE_EXT_EDGE   = 3'd3,
        MODE_RANGE      = 3'd4,
        MODE_RANGE_EDGE = 3'd5
    } tmu_mode_e;

    // Base compare family extracted from the mode.
    typedef enum logic [1:0] {
        BASE_EQ    = 2'd0,
        BASE_MAG   = 2'd1,
        BASE_WIN   = 2'd2,
        BASE_NONE  = 2'd3
    } tmu_base_e;

    // Operator for the extended (magnitude) compare.
    typedef enum logic [1:0] {
        OP_EQ = 2'd0,
        OP_NE = 2'd1,
        OP_GT = 2'd2,
        OP_LT = 2'd3
    } tmu_op_e;

    // Per-bit transition code in edge modes.
    typedef enum logic [1:0] {
        EDGE_LEVEL  = 2'd0,
        EDGE_RISE   = 2'd1,
        EDGE_FALL   = 2'd2,
        EDGE_EITHER = 2'd3
    } tmu_edge_e;

    // Split a raw mode code into base compare and edge flag.
    function automatic tmu_base_e mode_base(input logic [2:0] m);
        if (m > 3'd5) return BASE_NONE;
        return tmu_base_e'(m[2:1]);
    endfunction

    function automatic logic mode_has_edge(input logic [2:0] m);
        return (m <= 3'd5) && m[0];
    endfunction

endpackage

// File: rtl/tmu_history.sv
`timescale 1ns/1ps
// Module: tmu_history
// Keeps the previous probe sample and a flag telling whether one exists.
// Assumes: synchronous active-low reset; the flag is clear until the
// first sample after reset has been registered.
module tmu_history #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] probe_i,
    output logic [WIDTH-1:0] prev_o,
    output logic             prev_vld_o
);

    logic [WIDTH-1:0] prev_q;
    logic             vld_q;

    // Capture every sample and mark history valid after the first one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            vld_q  <= 1'b0;
        end else begin
            prev_q <= probe_i;
            vld_q  <= 1'b1;
        end
    end

    assign prev_o     = prev_q;
    assign prev_vld_o = vld_q;

endmodule

// File: rtl/tmu_compare.sv
`timescale 1ns/1ps
// Module: tmu_compare
// Combinational trigger condition for one probe sample. Evaluates the
// per-bit level and edge terms, the magnitude and the window compare,
// then selects by mode.
// Assumes: prev_i/prev_vld_i come from a register of the same probe.
module tmu_compare
    import trig_match_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0]   probe_i,
    input  logic [WIDTH-1:0]   prev_i,
    input  logic               prev_vld_i,
    input  logic [2:0]         mode_i,
    input  logic [WIDTH-1:0]   pat_lo_i,
    input  logic [WIDTH-1:0]   pat_hi_i,
    input  logic [WIDTH-1:0]   care_i,
    input  logic [2*WIDTH-1:0] edge_sel_i,
    input  logic [1:0]         ext_op_i,
    input  logic               range_out_i,
    output logic               hit_o
);

    tmu_base_e        base;
    logic             use_edge;
    logic [WIDTH-1:0] lvl_ok;
    logic [WIDTH-1:0] edg_ok;
    logic [WIDTH-1:0] probe_m;
    logic [WIDTH-1:0] pat_m;
    logic             mag_ok;
    logic             win_in;
    logic             base_ok;

    assign base     = mode_base(mode_i);
    assign use_edge = mode_has_edge(mode_i);
    assign probe_m  = probe_i & care_i;
    assign pat_m    = pat_lo_i & care_i;

    // Per-bit level and transition terms.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        tmu_edge_e code;
        logic      rise;
        logic      fall;
        assign code = use_edge ? tmu_edge_e'(edge_sel_i[2*i +: 2]) : EDGE_LEVEL;
        assign rise = !prev_i[i] &&  probe_i[i];
        assign fall =  prev_i[i] && !probe_i[i];

        // Level term: only cared bits coded as level take part.
        always_comb begin
            lvl_ok[i] = !care_i[i] || (code != EDGE_LEVEL) || (probe_i[i] == pat_lo_i[i]);
        end

        // Transition term: needs a valid previous sample.
        always_comb begin
            unique case (code)
                EDGE_LEVEL:  edg_ok[i] = 1'b1;
                EDGE_RISE:   edg_ok[i] = prev_vld_i && rise;
                EDGE_FALL:   edg_ok[i] = prev_vld_i && fall;
                EDGE_EITHER: edg_ok[i] = prev_vld_i && (rise || fall);
                default:     edg_ok[i] = 1'b0;
            endcase
            if (!care_i[i]) edg_ok[i] = 1'b1;
        end
    end

    // Magnitude compare of the masked probe against the masked pattern.
    always_comb begin
        unique case (tmu_op_e'(ext_op_i))
            OP_EQ:   mag_ok = (probe_m == pat_m);
            OP_NE:   mag_ok = (probe_m != pat_m);
            OP_GT:   mag_ok = (probe_m >  pat_m);
            OP_LT:   mag_ok = (probe_m <  pat_m);
            default: mag_ok = 1'b0;
        endcase
    end

    // Inclusive window test on the masked probe.
    assign win_in = (probe_m >= pat_lo_i) && (probe_m <= pat_hi_i);

    // Base compare selection by mode family.
    always_comb begin
        unique case (base)
            BASE_EQ:   base_ok = &lvl_ok;
            BASE_MAG:  base_ok = mag_ok;
            BASE_WIN:  base_ok = win_in ^ range_out_i;
            default:   base_ok = 1'b0;
        endcase
    end

    assign hit_o = base_ok && (&edg_ok);

endmodule

// File: rtl/tmu_occ_counter.sv
`timescale 1ns/1ps
// Module: tmu_occ_counter
// Counts compare-true cycles and raises a sticky flag at the target.
// CNT_W = 0 builds no counter: the flag rises on the first match.
// Assumes: clear has priority over counting in the same cycle.
module tmu_occ_counter #(
    parameter int CNT_W = 8,
    localparam int TW   = (CNT_W > 0) ? CNT_W : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hit_i,
    input  logic          clr_i,
    input  logic [TW-1:0] target_i,
    output logic          reached_o
);

    logic reached_q;

    if (CNT_W > 0) begin : g_cnt
        logic [CNT_W-1:0] cnt_q;
        logic [CNT_W-1:0] cnt_nxt;
        logic [CNT_W-1:0] tgt_eff;

        assign cnt_nxt = cnt_q + CNT_W'(1);
        assign tgt_eff = (target_i == '0) ? CNT_W'(1) : target_i;

        // Advance on a match until the target is reached; clear wins.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                cnt_q     <= '0;
                reached_q <= 1'b0;
            end else if (hit_i && !reached_q) begin
                cnt_q     <= cnt_nxt;
                reached_q <= (cnt_nxt == tgt_eff);
            end
        end
    end else begin : g_nocnt
        logic unused_tgt;
        assign unused_tgt = ^target_i;

        // Set on the first match, hold until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                reached_q <= 1'b0;
            end else if (hit_i) begin
                reached_q <= 1'b1;
            end
        end
    end

    assign reached_o = reached_q;

endmodule

// File: rtl/trig_match_unit.sv
`timescale 1ns/1ps
// Module: trig_match_unit (top)
// Compares a probe group with a programmed condition every clock, emits a
// registered match pulse and a sticky count-reached flag.
// Assumes: configuration inputs are quasi-static but may change any cycle;
// synchronous active-low reset.
module trig_match_unit #(
    parameter int WIDTH = 16,
    parameter int CNT_W = 8,
    localparam int TW   = (CNT_W > 0) ? CNT_W : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   probe_i,
    input  logic [2:0]         mode_i,
    input  logic [WIDTH-1:0]   pat_lo_i,
    input  logic [WIDTH-1:0]   pat_hi_i,
    input  logic [WIDTH-1:0]   care_i,
    input  logic [2*WIDTH-1:0] edge_sel_i,
    input  logic [1:0]         ext_op_i,
    input  logic               range_out_i,
    input  logic [TW-1:0]      target_i,
    input  logic               arm_clr_i,
    output logic               match_o,
    output logic               count_hit_o
);

    logic [WIDTH-1:0] prev;
    logic             prev_vld;
    logic             cmp_hit;
    logic             match_q;

    tmu_history #(.WIDTH(WIDTH)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .probe_i    (probe_i),
        .prev_o     (prev),
        .prev_vld_o (prev_vld)
    );

    tmu_compare #(.WIDTH(WIDTH)) u_cmp (
        .probe_i     (probe_i),
        .prev_i      (prev),
        .prev_vld_i  (prev_vld),
        .mode_i      (mode_i),
        .pat_lo_i    (pat_lo_i),
        .pat_hi_i    (pat_hi_i),
        .care_i      (care_i),
        .edge_sel_i  (edge_sel_i),
        .ext_op_i    (ext_op_i),
        .range_out_i (range_out_i),
        .hit_o       (cmp_hit)
    );

    tmu_occ_counter #(.CNT_W(CNT_W)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_i     (cmp_hit),
        .clr_i     (arm_clr_i),
        .target_i  (target_i),
        .reached_o (count_hit_o)
    );

    // Register the compare result into the match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= cmp_hit;
    end

    assign match_o = match_q;

endmodule

// File: rtl/tmu_checker.sv
`timescale 1ns/1ps
// Module: tmu_checker
// Temporal properties of trig_match_unit, observed at its ports.
// Assumes: bound to every trig_match_unit instance.
module tmu_checker #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] probe_i,
    input logic [2:0]       mode_i,
    input logic [WIDTH-1:0] pat_lo_i,
    input logic [WIDTH-1:0] pat_hi_i,
    input logic [WIDTH-1:0] care_i,
    input logic             range_out_i,
    input logic             arm_clr_i,
    input logic             match_o,
    input logic             count_hit_o
);

    // R1: reset drives both outputs low.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!match_o && !count_hit_o));

    // R2, R3: a masked equal sample in mode 0 yields a match one cycle later.
    p_basic_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd0 && (probe_i & care_i) == (pat_lo_i & care_i)) |=> match_o);

    // R5: above the high bound never matches an inside-window compare.
    p_window_above_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 3'd4 && !range_out_i && (probe_i & care_i) > pat_hi_i) |=> !match_o);

    // R8: illegal modes never match.
    p_illegal_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i > 3'd5) |=> !match_o);

    // R9: the flag only rises together with a match pulse.
    p_hit_with_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count_hit_o) |-> match_o);

    // R10: the flag holds until cleared, and a clear drops it.
    p_hit_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (count_hit_o && !arm_clr_i) |=> count_hit_o);

    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        arm_clr_i |=> !count_hit_o);

endmodule

bind trig_match_unit tmu_checker #(.WIDTH(WIDTH)) u_tmu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .probe_i     (probe_i),
    .mode_i      (mode_i),
    .pat_lo_i    (pat_lo_i),
    .pat_hi_i    (pat_hi_i),
    .care_i      (care_i),
    .range_out_i (range_out_i),
    .arm_clr_i   (arm_clr_i),
    .match_o     (match_o),
    .count_hit_o (count_hit_o)
);

// File: tb/tb_trig_match_unit.sv
`timescale 1ns/1ps
// Bench for trig_match_unit: directed corners plus seeded random stimulus,
// checked against a cycle model computed in bench functions.
module tb_trig_match_unit;

    localparam int W  = 8;
    localparam int CW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [W-1:0]   probe, pat_lo, pat_hi, care;
    logic [2*W-1:0] esel;
    logic [2:0]     mode;
    logic [1:0]     op;
    logic           rout, clr;
    logic [CW-1:0]  tgt;
    logic           match_a, hit_a, match_b, hit_b;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    trig_match_unit #(.WIDTH(W), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .mode_i(mode),
        .pat_lo_i(pat_lo), .pat_hi_i(pat_hi), .care_i(care), .edge_sel_i(esel),
        .ext_op_i(op), .range_out_i(rout), .target_i(tgt), .arm_clr_i(clr),
        .match_o(match_a), .count_hit_o(hit_a));

    trig_match_unit #(.WIDTH(W), .CNT_W(0)) dut_nocnt (
        .clk(clk), .rst_n(rst_n), .probe_i(probe), .mode_i(mode),
        .pat_lo_i(pat_lo), .pat_hi_i(pat_hi), .care_i(care), .edge_sel_i(esel),
        .ext_op_i(op), .range_out_i(rout), .target_i(tgt[0]), .arm_clr_i(clr),
        .match_o(match_b), .count_hit_o(hit_b));

    // Model state.
    logic [W-1:0]  m_prev;
    bit            m_pv;
    bit            e_match, e_hit, e_hit0;
    logic [CW-1:0] m_cnt;
    string         e_tag;

    function automatic bit model_cmp(input logic [2:0] md, input logic [W-1:0] p,
                                     input logic [W-1:0] pv_s, input bit pv);
        bit edg = (md <= 3) ? md[0] : (md == 5);
        bit eq_ok = 1, eok = 1, base;
        logic [W-1:0] pm = p & care;
        logic [W-1:0] tm = pat_lo & care;
        for (int i = 0; i < W; i++) begin
            logic [1:0] c = edg ? esel[2*i +: 2] : 2'd0;
            if (care[i]) begin
                if (c == 0 && p[i] != pat_lo[i]) eq_ok = 0;
                if (c == 1 && !(pv && !pv_s[i] && p[i])) eok = 0;
                if (c == 2 && !(pv && pv_s[i] && !p[i])) eok = 0;
                if (c == 3 && !(pv && pv_s[i] != p[i])) eok = 0;
            end
        end
        case (md)
            0, 1: base = eq_ok;
            2, 3: case (op)
                      0: base = (pm == tm);
                      1: base = (pm != tm);
                      2: base = (pm > tm);
                      default: base = (pm < tm);
                  endcase
            4, 5: base = ((pm >= pat_lo) && (pm <= pat_hi)) != rout;
            default: return 0;
        endcase
        return base && eok;
    endfunction

    function automatic string tag_of(input logic [2:0] md);
        case (md)
            0: return "R2";
            2: return "R4";
            4: return "R5";
            1, 3, 5: return "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit act, input bit exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    // One clock: update the model from applied inputs, then compare at negedge.
    task automatic cyc(input string mtag = "");
        bit c;
        logic [CW-1:0] tg;
        if (!rst_n) begin
            e_match = 0; e_hit = 0; e_hit0 = 0; m_cnt = 0; m_pv = 0; m_prev = '0;
            e_tag = "R1";
        end else begin
            c = model_cmp(mode, probe, m_prev, m_pv);
            e_match = c;
            e_tag = (mtag != "") ? mtag : tag_of(mode);
            tg = (tgt == 0) ? CW'(1) : tgt;
            if (clr) begin
                m_cnt = 0; e_hit = 0; e_hit0 = 0;
            end else begin
                if (c && !e_hit) begin
                    m_cnt = m_cnt + 1'b1;
                    e_hit = (m_cnt == tg);
                end
                if (c) e_hit0 = 1;
            end
            m_prev = probe; m_pv = 1;
        end
        @(negedge clk);
        check(match_a, e_match, e_tag);
        check(hit_a, e_hit, (e_tag == "R1") ? "R1" : "R9 R10");
        check(hit_b, e_hit0, (e_tag == "R1") ? "R1" : "R11");
    endtask

    task automatic idle_cfg();
        mode = 3'd0; care = '0; pat_lo = '0; pat_hi = '0; esel = '0;
        op = 2'd0; rout = 0; clr = 0; probe = '0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        idle_cfg(); tgt = 4'd3; rst_n = 0;
        @(negedge clk);
        cyc(); cyc();                               // R1 reset state
        rst_n = 1;

        // R7: edge-coded rising bit already high in the first sample.
        mode = 3'd1; care = 8'h01; esel = 16'h0001; probe = 8'h01;
        cyc("R7");
        probe = 8'h00; cyc("R6");
        probe = 8'h01; cyc("R6");                   // genuine rising edge
        esel = 16'h0002; probe = 8'h00; cyc("R6");  // falling
        esel = 16'h0003; probe = 8'h01; cyc("R6");  // either
        probe = 8'h01; cyc("R6");                   // no change

        // R3: latency; freshly applied match not visible before the edge.
        clr = 1; mode = 3'd6; cyc("R8"); clr = 0;
        mode = 3'd0; care = 8'hF0; pat_lo = 8'hA5; probe = 8'hA3;
        check(match_a, 1'b0, "R3");
        cyc("R2");
        probe = 8'h53; cyc("R2");

        // R4: magnitude boundaries with equal operands.
        mode = 3'd2; care = 8'hFF; pat_lo = 8'h40; probe = 8'h40;
        for (int k = 0; k < 4; k++) begin op = 2'(k); cyc("R4"); end
        op = 2'd2; probe = 8'h41; cyc("R4");
        op = 2'd3; probe = 8'h3F; cyc("R4");

        // R5: window edges, inside and outside.
        mode = 3'd4; pat_lo = 8'h10; pat_hi = 8'h20; op = 0;
        probe = 8'h10; cyc("R5"); probe = 8'h20; cyc("R5");
        probe = 8'h21; cyc("R5"); probe = 8'h0F; cyc("R5");
        rout = 1; probe = 8'h21; cyc("R5"); probe = 8'h15; cyc("R5");
        rout = 0;

        // R9 R10: count to 3, keep matching, clear in a matching cycle.
        clr = 1; mode = 3'd6; cyc("R8"); clr = 0;
        mode = 3'd0; care = 8'h00; tgt = 4'd3;
        repeat (5) cyc("R9");
        clr = 1; cyc("R10"); clr = 0;
        tgt = 4'd0; cyc("R9");                      // target 0 acts as 1
        mode = 3'd7; repeat (2) cyc("R8");

        // Random mix.
        for (int n = 0; n < 4000; n++) begin
            mode  = 3'($urandom_range(0, 7));
            care  = 8'($urandom) & 8'($urandom);
            probe = 8'($urandom_range(0, 63));
            pat_lo = 8'($urandom_range(0, 40));
            pat_hi = 8'($urandom_range(20, 63));
            esel  = 16'($urandom);
            op    = 2'($urandom);
            rout  = ($urandom_range(0, 7) == 0);
            clr   = ($urandom_range(0, 15) == 0);
            if (clr) tgt = 4'($urandom_range(0, 6));
            cyc();
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule